// File: doc/BRIEF.md
# One-Second Phase Error Meter with 30-Second Aggregation

This block measures how far a disciplined oscillator lags a once-per-second reference pulse. The oscillator is divided down by a parameter `DIV_N` (32 for a 10 MHz oscillator, 16 for 5 MHz). Each second the block opens a gate on the rising edge of the reference pulse and closes it on the next rising edge of the divided oscillator. While the gate is open it counts cycles of a fast counting clock, which is unrelated to the oscillator. With a 24 MHz counting clock and a 3.2 us window, one second yields about 77 counts. The slow drift between the two clocks averages out the one-count quantisation.

Thirty of these one-second counts are summed. The sum runs from 0, when both edges coincide, to about 2304 at full scale. A programmable setpoint is subtracted from the sum, and the signed result is presented to a loop filter together with a one-cycle strobe. The reference pulse and the divided oscillator both reach the counting-clock domain through two-flop synchronisers with rising-edge detection.

The gate controller has two states: `G_SHUT` (gate closed, waiting for a reference edge) and `G_OPEN` (counting). It moves from `G_SHUT` to `G_OPEN` on a reference edge that comes alone. It stays in `G_SHUT` and records zero when both edges arrive together. It moves from `G_OPEN` to `G_SHUT` on a close edge, or when the count reaches `CNT_MAX`. The aggregator also has two states. `A_PRIME` sums the first window after reset and throws it away. `A_RUN` reports every window that follows. The only transition is from `A_PRIME` to `A_RUN`, taken when the first window completes.

Top module: `pps_phase_meter`

## Requirements
- R1: While reset is asserted and after it is released, `phase_err` is 0 and `err_valid` is low until a window is reported.
- R2: One measurement equals k, the number of counting-clock cycles between the synchronised reference edge and the synchronised close edge.
- R3: When the reference edge and the close edge are detected in the same cycle, the measurement is 0.
- R4: When no close edge arrives within `CNT_MAX` (127) cycles, the measurement is 127 and the gate is forced closed.
- R5: A divided-oscillator edge that arrives while the gate is closed is ignored. It does not change any later measurement.
- R6: After every `WIN_LEN` (30) measurements, `phase_err` becomes the sum of those measurements minus `setpoint`. The result is signed two's complement, `ERR_W` bits wide.
- R7: `err_valid` is high for exactly one cycle per reported window, in the cycle in which `phase_err` takes its new value. The next window's sum starts again from zero.
- R8: The first complete window after reset is discarded. It produces no strobe and leaves `phase_err` at 0.
- R9: `setpoint` is applied at each report, so that different values (for example 800, 1024 or 1152) shift the reported error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cnt | input | 1 | Fast counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_in | input | 1 | Once-per-second reference pulse, asynchronous |
| osc_in | input | 1 | Oscillator clock to be divided by DIV_N |
| setpoint | input | SUM_W (12) | Value subtracted from each 30-second sum |
| phase_err | output | ERR_W (13) | Signed aggregated phase error |
| err_valid | output | 1 | One-cycle strobe marking a new phase_err |

## Verification
The bench sweeps the edge spacing k across windows. It covers coincident edges, a ramp in steps of four, a constant small offset, spacings of exactly 126 and 127, and windows in which no close edge arrives at all. Each window's sum and signed error are predicted arithmetically. A design that counted one cycle too many or too few, or that opened the gate on coincident edges, would be off by up to 30 counts or would fill the whole count. One that did not saturate, or that acted on a close edge while the gate was shut, would corrupt the saturated windows. One that reported the first window, or that strobed for more than a cycle, would change the strobe count.

// File: rtl/pps_meter_pkg.sv
package pps_meter_pkg;
    typedef enum logic {
        G_SHUT = 1'b0,
        G_OPEN = 1'b1
    } gate_state_t;

    typedef enum logic {
        A_PRIME = 1'b0,
        A_RUN   = 1'b1
    } acc_state_t;
endpackage

// File: rtl/pps_sync_rise.sv
module pps_sync_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic stage1, stage2, stage3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            stage2 <= 1'b0;
            stage3 <= 1'b0;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
            stage3 <= stage2;
        end
    end

    assign rise = stage2 & ~stage3;
endmodule

// File: rtl/pps_osc_divider.sv
module pps_osc_divider #(
    parameter int DIV_N = 32,
    localparam int CW   = $clog2(DIV_N)
) (
    input  logic osc_clk,
    input  logic rst_n,
    output logic div_out
);
    logic [CW-1:0] cnt, cnt_nx;

    always_comb begin
        cnt_nx = (cnt == CW'(DIV_N - 1)) ? '0 : cnt + 1'b1;
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            div_out <= 1'b0;
        end else begin
            cnt     <= cnt_nx;
            div_out <= (cnt_nx != '0) && (cnt_nx <= CW'(DIV_N / 2));
        end
    end
endmodule

// File: rtl/pps_gate_fsm.sv
module pps_gate_fsm
    import pps_meter_pkg::*;
#(
    parameter int CNT_MAX = 127,
    localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise,
    input  logic             close_rise,
    output logic             meas_done,
    output logic [CNT_W-1:0] meas
);
    gate_state_t      state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             at_cap;

    assign at_cap = (cnt == CNT_W'(CNT_MAX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= G_SHUT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            G_SHUT: if (ref_rise && !close_rise) state_nx = G_OPEN;
            G_OPEN: if (close_rise || at_cap)    state_nx = G_SHUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            meas      <= '0;
            meas_done <= 1'b0;
        end else begin
            meas_done <= 1'b0;
            unique case (state)
                G_SHUT: begin
                    if (ref_rise) begin
                        if (close_rise) begin
                            meas      <= '0;
                            meas_done <= 1'b1;
                        end else begin
                            cnt <= CNT_W'(1);
                        end
                    end
                end
                G_OPEN: begin
                    if (close_rise || at_cap) begin
                        meas      <= cnt;
                        meas_done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    a_r3_coincident_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == G_SHUT && ref_rise && close_rise) |=> (meas_done && meas == '0));

    a_r4_forced_close: assert property (@(posedge clk) disable iff (!rst_n)
        (state == G_OPEN && at_cap) |=> (state == G_SHUT && meas_done && meas == CNT_W'(CNT_MAX)));

    a_r5_shut_ignores_close: assert property (@(posedge clk) disable iff (!rst_n)
        (state == G_SHUT && close_rise && !ref_rise) |=> (!meas_done && state == G_SHUT));

    a_r2_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
        (state == G_OPEN && !close_rise && !at_cap) |=> (state == G_OPEN && !meas_done));
endmodule

// File: rtl/pps_window_acc.sv
module pps_window_acc
    import pps_meter_pkg::*;
#(
    parameter int WIN_LEN = 30,
    parameter int CNT_W   = 7,
    parameter int SUM_W   = 12,
    localparam int SLOT_W = $clog2(WIN_LEN),
    localparam int ERR_W  = SUM_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    meas_done,
    input  logic [CNT_W-1:0]        meas,
    input  logic [SUM_W-1:0]        setpoint,
    output logic signed [ERR_W-1:0] err,
    output logic                    err_valid
);
    acc_state_t        state, state_nx;
    logic [SLOT_W-1:0] slot;
    logic [SUM_W-1:0]  sum, total;
    logic              last_slot;

    assign last_slot = (slot == SLOT_W'(WIN_LEN - 1));
    assign total     = sum + SUM_W'(meas);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= A_PRIME;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            A_PRIME: if (meas_done && last_slot) state_nx = A_RUN;
            A_RUN:   state_nx = A_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot      <= '0;
            sum       <= '0;
            err       <= '0;
            err_valid <= 1'b0;
        end else begin
            err_valid <= 1'b0;
            if (meas_done) begin
                if (last_slot) begin
                    slot <= '0;
                    sum  <= '0;
                    if (state == A_RUN) begin
                        err       <= $signed({1'b0, total}) - $signed({1'b0, setpoint});
                        err_valid <= 1'b1;
                    end
                end else begin
                    slot <= slot + 1'b1;
                    sum  <= total;
                end
            end
        end
    end

    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);

    a_r6_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (slot == '0 && sum == '0));

    a_r8_prime_silent: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(state == A_RUN));

    a_r1_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> $stable(err));
endmodule

// File: rtl/pps_phase_meter.sv
module pps_phase_meter #(
    parameter int DIV_N   = 32,
    parameter int WIN_LEN = 30,
    parameter int CNT_MAX = 127,
    localparam int CNT_W  = $clog2(CNT_MAX + 1),
    localparam int SUM_W  = $clog2(WIN_LEN * CNT_MAX + 1),
    localparam int ERR_W  = SUM_W + 1
) (
    input  logic                    clk_cnt,
    input  logic                    rst_n,
    input  logic                    pps_in,
    input  logic                    osc_in,
    input  logic [SUM_W-1:0]        setpoint,
    output logic signed [ERR_W-1:0] phase_err,
    output logic                    err_valid
);
    logic             div_clk;
    logic             ref_rise, close_rise;
    logic             meas_done;
    logic [CNT_W-1:0] meas;

    pps_osc_divider #(.DIV_N(DIV_N)) u_div (
        .osc_clk (osc_in),
        .rst_n   (rst_n),
        .div_out (div_clk)
    );

    pps_sync_rise u_ref_sync (
        .clk      (clk_cnt),
        .rst_n    (rst_n),
        .async_in (pps_in),
        .rise     (ref_rise)
    );

    pps_sync_rise u_close_sync (
        .clk      (clk_cnt),
        .rst_n    (rst_n),
        .async_in (div_clk),
        .rise     (close_rise)
    );

    pps_gate_fsm #(.CNT_MAX(CNT_MAX)) u_gate (
        .clk        (clk_cnt),
        .rst_n      (rst_n),
        .ref_rise   (ref_rise),
        .close_rise (close_rise),
        .meas_done  (meas_done),
        .meas       (meas)
    );

    pps_window_acc #(
        .WIN_LEN (WIN_LEN),
        .CNT_W   (CNT_W),
        .SUM_W   (SUM_W)
    ) u_acc (
        .clk       (clk_cnt),
        .rst_n     (rst_n),
        .meas_done (meas_done),
        .meas      (meas),
        .setpoint  (setpoint),
        .err       (phase_err),
        .err_valid (err_valid)
    );
endmodule

// File: tb/test_pps_phase_meter.sv
module test_pps_phase_meter;
    localparam int N   = 32;
    localparam int WIN = 30;
    localparam int CAP = 127;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               pps = 1'b0;
    logic               osc = 1'b0;
    logic [11:0]        sp = 12'd1152;
    logic signed [12:0] err;
    logic               vld;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    int width_bad = 0;
    int last_err = 0;
    int osc_edges = 0;
    logic prev_vld = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pps_phase_meter i_pps_phase_meter (
        .clk_cnt   (clk),
        .rst_n     (rst_n),
        .pps_in    (pps),
        .osc_in    (osc),
        .setpoint  (sp),
        .phase_err (err),
        .err_valid (vld)
    );

    always @(negedge clk) begin
        if (vld) begin
            vcount++;
            last_err = int'(err);
            if (prev_vld) width_bad++;
        end
        prev_vld = vld;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic osc_pulse();
        osc = 1'b1;
        #1 osc = 1'b0;
        osc_edges++;
    endtask

    // bring the divider to the phase just before its next rising output
    task automatic osc_prep();
        while (osc_edges % N != 0) begin
            @(negedge clk);
            osc_pulse();
        end
    endtask

    // one second: close edge k cycles after the reference edge; k > CAP means none in time
    task automatic second(input int k);
        osc_prep();
        repeat (3) @(negedge clk);
        pps = 1'b1;
        if (k <= CAP) begin
            for (int j = 0; j < k; j++) @(negedge clk);
            osc_pulse();
        end else begin
            for (int j = 0; j < CAP + 6; j++) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        pps = 1'b0;
        if (k > CAP) begin
            for (int j = CAP + 6; j < k; j++) @(negedge clk);
            osc_pulse(); // stray close edge while the gate is shut (R5)
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int snap;
        int exp;
        repeat (4) @(negedge clk);
        check("R1 phase_err in reset", int'(err), 0);
        check("R1 err_valid in reset", int'(vld), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 phase_err after reset", int'(err), 0);

        // window 1: discarded (R8)
        for (int i = 0; i < WIN; i++) second(10);
        repeat (5) @(negedge clk);
        check("R8 no strobe for first window", vcount, 0);
        check("R8 phase_err untouched", int'(err), 0);

        // window 2: ramp including coincident edges (R2, R3, R6)
        snap = vcount;
        exp = 0;
        for (int i = 0; i < WIN; i++) begin
            second(i * 4);
            exp += i * 4;
        end
        repeat (5) @(negedge clk);
        check("R7 one strobe for ramp window", vcount - snap, 1);
        check("R2 R3 R6 ramp error", last_err, exp - 1152);

        // window 3: one coincident-edge window alone (R3)
        snap = vcount;
        sp = 12'd0;
        for (int i = 0; i < WIN; i++) second(0);
        repeat (5) @(negedge clk);
        check("R3 coincident edges give zero", last_err, 0);
        check("R7 strobe count coincident window", vcount - snap, 1);

        // window 4: no close edge in time, stray edges while shut (R4, R5, R9)
        snap = vcount;
        sp = 12'd800;
        for (int i = 0; i < WIN; i++) second(160);
        repeat (5) @(negedge clk);
        check("R4 R9 saturated window", last_err, WIN * CAP - 800);
        check("R7 strobe count saturated window", vcount - snap, 1);

        // window 5: small constant offset, negative error (R2, R6, R9)
        snap = vcount;
        sp = 12'd1024;
        for (int i = 0; i < WIN; i++) second(5);
        repeat (5) @(negedge clk);
        check("R2 R6 negative error", last_err, WIN * 5 - 1024);
        check("R6 phase_err port holds value", int'(err), WIN * 5 - 1024);

        // window 6: boundary spacing 126 alternating with a late edge (R4, R5)
        snap = vcount;
        sp = 12'd4095;
        exp = 0;
        for (int i = 0; i < WIN; i++) begin
            if (i % 2 == 0) begin second(126); exp += 126; end
            else begin second(200); exp += CAP; end
        end
        repeat (5) @(negedge clk);
        check("R4 R5 boundary window", last_err, exp - 4095);

        // window 7: spacing exactly at the cap, mid setpoint (R2, R4)
        snap = vcount;
        sp = 12'd1152;
        for (int i = 0; i < WIN; i++) second(CAP);
        repeat (5) @(negedge clk);
        check("R2 R4 spacing at cap", last_err, WIN * CAP - 1152);
        check("R7 strobe count cap window", vcount - snap, 1);

        check("R7 strobe never wider than one cycle", width_bad, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule